// File: doc/BRIEF.md
# Load Power Meter and Switch-Segment Selector

This block gives a buck converter's digital controller a coarse figure for load power and uses it to choose how many parallel power-switch segments to drive. A sensing ramp produces a comparator that flips faster as inductor current rises. The block synchronizes that comparator and counts its transitions, but only while the high-side switch conducts, over a fixed window of system clocks. The output-voltage code already comes from the thermal compensation loop, so only current has to be measured. Each window's count is multiplied by that voltage code to give a saturated 16-bit power estimate.

The estimate is compared against seven ascending programmable thresholds, which gives a 3-bit class from 0 to 7. The class selects a thermometer of segment enables. Light load keeps only the smallest segment on, which cuts switching loss. Heavy load turns all seven on, which cuts conduction loss. The same enable vector goes to the low-side and the high-side arrays. A new class is taken up only on a start-of-switching-cycle strobe, so no segment changes in the middle of a pulse.

Top module: `load_power_seg`

## Requirements
- R1: After reset, `level` is 0, and both `nseg_en` and `pseg_en` are 7'b0000001.
- R2: Every transition of `cmp_toggle`, rising or falling, is counted once when `hs_on` is high as it reaches the counter. The count runs over a window of WIN clocks (default 256) that starts at reset release. At the window's last clock the count is latched, including any edge counted in that clock, and the counter is cleared.
- R3: Transitions that arrive while `hs_on` is low are not counted. A window with `hs_on` held low yields a count of 0.
- R4: The power estimate is the latched count times the `vcode` present when the strobe is taken, saturated to 65535.
- R5: The class equals the number of thresholds that the estimate meets or exceeds, where an estimate equal to a threshold counts as exceeding it. Threshold k (k = 0..6) occupies `thr_flat[16*k +: 16]`, and the thresholds are ascending.
- R6: For class G, enable bits 0 through min(6, G) are set and the rest are clear. Bit 0 is always set.
- R7: `pseg_en` always equals `nseg_en`.
- R8: `level` and the enables change only on a clock where `cycle_start` is high. If the strobe coincides with a window's last clock, it applies the class computed from the previous window's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_toggle | input | 1 | Asynchronous comparator output from the current ramp |
| hs_on | input | 1 | High-side switch conducting |
| vcode | input | 10 | Output-voltage code from the thermal loop |
| thr_flat | input | 112 | Seven ascending 16-bit class thresholds, threshold k at bits 16k+15:16k |
| cycle_start | input | 1 | Start-of-switching-cycle strobe |
| level | output | 3 | Applied load class |
| nseg_en | output | 7 | Low-side segment enables |
| pseg_en | output | 7 | High-side segment enables |

## Verification
Two functions can land on the same clock: the window's last clock, which latches a new count, and the switching-cycle strobe, which applies a class. The bench raises the strobe exactly on that clock after a window whose count differs from the one before. It expects the applied class to come from the earlier count, and it expects the new count to appear only at the next strobe. Every window is also checked just before its strobe, to confirm that the freshly latched count has not yet moved the enables.

// File: rtl/load_power_seg.sv
module load_power_seg #(
  parameter int WIN  = 256,
  parameter int VW   = 10,
  parameter int PW   = 16,
  parameter int NSEG = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_toggle,
  input  logic                 hs_on,
  input  logic [VW-1:0]        vcode,
  input  logic [NSEG*PW-1:0]   thr_flat,
  input  logic                 cycle_start,
  output logic [$clog2(NSEG+1)-1:0] level,
  output logic [NSEG-1:0]      nseg_en,
  output logic [NSEG-1:0]      pseg_en
);
  localparam int CW  = $clog2(WIN + 1);
  localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int LW  = $clog2(NSEG + 1);
  localparam int FW  = CW + VW;

  logic [2:0]     sy;
  logic [WCW-1:0] wcnt;
  logic [CW-1:0]  cnt, cnt_lat;
  logic [FW-1:0]  prod;
  logic [PW-1:0]  power;
  logic [LW-1:0]  lvl_next;
  logic           inc, last;

  assign inc  = (sy[1] ^ sy[2]) & hs_on;
  assign last = (wcnt == WCW'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], cmp_toggle};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt    <= '0;
      cnt     <= '0;
      cnt_lat <= '0;
    end else if (last) begin
      wcnt    <= '0;
      cnt     <= '0;
      cnt_lat <= cnt + CW'(inc);
    end else begin
      wcnt    <= wcnt + 1'b1;
      cnt     <= cnt + CW'(inc);
    end

  assign prod = FW'(cnt_lat) * FW'(vcode);

  generate
    if (FW > PW) begin : g_sat
      assign power = (|prod[FW-1:PW]) ? '1 : prod[PW-1:0];
    end else begin : g_nosat
      assign power = PW'(prod);
    end
  endgenerate

  always_comb begin
    lvl_next = '0;
    for (int k = 0; k < NSEG; k++)
      if (power >= thr_flat[k*PW +: PW]) lvl_next = lvl_next + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           level <= '0;
    else if (cycle_start) level <= lvl_next;

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
      assign nseg_en[i] = (LW'(i) <= level);
    end
  endgenerate
  assign pseg_en = nseg_en;

  assert_seg0_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nseg_en[0]);
  assert_thermo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((nseg_en & (nseg_en + 1'b1)) == '0));
  assert_arrays_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pseg_en == nseg_en);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(level));
  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_on && !last) |=> $stable(cnt));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt == '0));
endmodule

// File: tb/sim_load_power_seg.sv
module sim_load_power_seg;
  localparam int WIN = 256;
  logic clk = 0, rst_n = 0, cmp = 0, hs = 0, cs = 0;
  logic [9:0]   vcode = '0;
  logic [111:0] thr;
  logic [2:0]   level;
  logic [6:0]   nseg_en, pseg_en;
  int cyc = 0, nchk = 0, nfail = 0, applied = 0, prev_cnt = 0;
  bit done = 0;
  int th[7] = '{2000, 5000, 9000, 14000, 20000, 30000, 45000};

  always #5 clk = ~clk;

  load_power_seg u0 (.clk(clk), .rst_n(rst_n), .cmp_toggle(cmp), .hs_on(hs),
    .vcode(vcode), .thr_flat(thr), .cycle_start(cs), .level(level),
    .nseg_en(nseg_en), .pseg_en(pseg_en));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int exp_lvl(int n, int v);
    int p = n * v;
    int l = 0;
    if (p > 65535) p = 65535;
    for (int k = 0; k < 7; k++) if (p >= th[k]) l++;
    return l;
  endfunction

  function automatic int exp_en(int l);
    int m = (l + 1 > 7) ? 7 : l + 1;
    return (1 << m) - 1;
  endfunction

  task automatic check(string req, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_out(string req, int l);
    check(req, level, l);
    check({req, " nseg"}, nseg_en, exp_en(l));
    check({req, " R7 pseg"}, pseg_en, nseg_en);
  endtask

  task automatic wait_phase(int p);
    @(negedge clk);
    while ((cyc % WIN) != p) @(negedge clk);
  endtask

  task automatic toggles(int n, int v, bit h);
    wait_phase(8);
    vcode = 10'(v);
    hs = h;
    for (int i = 0; i < n; i++) begin
      cmp = ~cmp;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic strobe;
    cs = 1;
    @(negedge clk);
    cs = 0;
  endtask

  task automatic run_window(int n, int v, bit h, string req);
    int c = h ? n : 0;
    toggles(n, v, h);
    wait_phase(0);
    check_out("R8 hold before strobe", applied);
    strobe();
    applied = exp_lvl(c, v);
    check_out(req, applied);
    prev_cnt = c;
  endtask

  initial begin
    for (int k = 0; k < 7; k++) thr[k*16 +: 16] = 16'(th[k]);
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_out("R1 reset", 0);
    rst_n = 1;
    run_window(0, 500, 1, "R2 zero count");
    run_window(20, 100, 1, "R5 equal threshold");
    run_window(19, 100, 1, "R5 just below threshold");
    run_window(50, 200, 1, "R2 R5 mid class");
    run_window(100, 1000, 1, "R4 saturation");
    run_window(90, 600, 0, "R3 hs low ignored");
    run_window(45, 1000, 1, "R6 class7 all on");
    run_window(35, 1000, 1, "R6 class6");
    toggles(10, 1000, 1);
    wait_phase(WIN - 1);
    strobe();
    applied = exp_lvl(prev_cnt, 1000);
    check_out("R8 coincident strobe uses previous", applied);
    @(negedge clk);
    strobe();
    applied = exp_lvl(10, 1000);
    check_out("R8 next strobe uses new", applied);
    prev_cnt = 10;
    for (int r = 0; r < 30; r++) begin
      int n = int'($urandom % 111);
      int v = int'($urandom % 1024);
      bit h = ($urandom % 4) != 0;
      run_window(n, v, h, "R2 R4 R5 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule